// File: doc/BRIEF.md
# Link-Configuration Write Snooper

This block sits beside a display auxiliary channel and listens to write transactions that another unit has already decoded. Each write reaches it as an address, a data byte and a one-cycle valid strobe. When a write targets one of the link-configuration registers, the block updates a local shadow copy. It then presents the decoded result to the main-link driver and to the mode controller: a high/low rate select, a lane enable mask, swing and pre-emphasis codes for each lane, and a power-down state with entry and exit pulses.

Every stored entry is checked against its legal encodings. An out-of-range lane count, or a lane setting whose swing and pre-emphasis levels together exceed the allowed budget, raises a single output-disable flag. That flag forces every lane off. It drops on its own as soon as all checked entries are legal again, so the source can retrain with corrected values. While the shutdown input is high, all shadow state is held at its defaults and writes are not recorded.

Top module: `dpcd_snoop_top`

## Requirements
- R1: After reset the outputs are: rate_high 0, lane_en 0000, all swing and pre-emphasis codes 0, pwr_down 0, out_disable 0, d3_enter 0, d3_exit 0.
- R2: A write to address 0x100 with data 0x0A sets rate_high to 1. A write of any other byte to 0x100 sets it to 0.
- R3: A write to 0x101 uses only data bits 4:0; bits 7:5 have no effect. The value 1 gives lane_en 0001, the value 2 gives 0011, and the value 4 gives 1111.
- R4: After a write to 0x101 whose bits 4:0 are anything other than 1, 2 or 4, out_disable is 1 and lane_en is 0000 until legal entries are written.
- R5: A write to address 0x103+n (n = 0..3) stores data bits 1:0 as the swing code of lane n, on swing_lvl[2n+1:2n]. It stores data bits 4:3 as the pre-emphasis code of lane n, on preemph_lvl[2n+1:2n].
- R6: A lane whose swing code plus pre-emphasis code exceeds 3 makes out_disable 1 and lane_en 0000. This is the set of pairs 01/11, 10/10, 10/11, 11/01, 11/10, 11/11. The check applies to all four lanes. Once every checked entry is legal, out_disable returns to 0 and the mask from R3 returns.
- R7: A write to 0x600 with bits 1:0 = 10 while in normal mode sets pwr_down and pulses d3_enter for one cycle. A write with bits 1:0 = 01 while powered down clears pwr_down and pulses d3_exit for one cycle.
- R8: A write to 0x600 with bits 1:0 = 00 or 11 leaves pwr_down unchanged and produces no pulse.
- R9: A write to any address other than 0x100, 0x101, 0x103 to 0x106 and 0x600 changes no output.
- R10: While shutdown is 1, all outputs hold their R1 values and writes are discarded.
- R11: Every output reflects a write in the first cycle after the clock edge that samples wr_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Holds all shadow state at defaults |
| wr_valid | input | 1 | Decoded write strobe, one cycle per write |
| wr_addr | input | 20 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| rate_high | output | 1 | 1 selects the high link rate |
| lane_en | output | 4 | Thermometer lane enable mask, bit n for lane n |
| swing_lvl | output | 8 | Swing code, two bits per lane |
| preemph_lvl | output | 8 | Pre-emphasis code, two bits per lane |
| pwr_down | output | 1 | Power-down state requested over the channel |
| d3_enter | output | 1 | One-cycle pulse on entry to power-down |
| d3_exit | output | 1 | One-cycle pulse on exit from power-down |
| out_disable | output | 1 | Some checked entry is illegal; all lanes are forced off |

## Verification
Several properties are checked by assertions on every cycle. The lane mask always keeps a thermometer shape and is empty whenever out_disable is set. The rate and lane fields follow the write of the previous cycle. Power pulses occur only on an actual change of pwr_down, and ignored power codes leave it still. Writes to unlisted addresses leave every output stable, and a cycle of shutdown leaves the defaults in place. Other behaviour can only be shown by the bench's scenarios: the exact mask value for each count, the way out_disable latches across writes to different registers and clears only when the last illegal entry is replaced, and the per-lane placement of the codes.

// File: rtl/dpcd_snoop_pkg.sv
package dpcd_snoop_pkg;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 8;
    localparam int N_LANES = 4;
    localparam int CODE_W  = 2;

    localparam logic [ADDR_W-1:0] A_RATE   = 20'h00100;
    localparam logic [ADDR_W-1:0] A_COUNT  = 20'h00101;
    localparam logic [ADDR_W-1:0] A_LANE0  = 20'h00103;
    localparam logic [ADDR_W-1:0] A_POWER  = 20'h00600;

    localparam logic [DATA_W-1:0] RATE_DEFAULT = 8'h06;
    localparam logic [DATA_W-1:0] RATE_HI_CODE = 8'h0A;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        PWR_RSVD0  = 2'b00,
        PWR_NORMAL = 2'b01,
        PWR_DOWN   = 2'b10,
        PWR_RSVD3  = 2'b11
    } pwr_code_e;

    typedef struct packed {
        logic [DATA_W-1:0] rate;
        logic [CNT_W-1:0]  cnt;
        logic              cnt_set;
    } link_st_t;

    localparam link_st_t LINK_RST = '{rate: RATE_DEFAULT, cnt: '0, cnt_set: 1'b0};

    typedef struct packed {
        logic [CODE_W-1:0] swing;
        logic [CODE_W-1:0] pre;
    } lane_st_t;

    typedef struct packed {
        logic down;
        logic enter;
        logic leave;
    } pwr_st_t;

    // Legal drive budget: swing level plus pre-emphasis level at most 3.
    function automatic logic pair_legal(input logic [CODE_W-1:0] swing,
                                        input logic [CODE_W-1:0] pre);
        logic [CODE_W:0] sum;
        sum = {1'b0, swing} + {1'b0, pre};
        return (sum <= (CODE_W+1)'(3));
    endfunction

endpackage

// File: rtl/dpcd_link_cfg.sv
module dpcd_link_cfg
    import dpcd_snoop_pkg::*;
#(
    parameter int LANES = N_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rate_high,
    output logic [LANES-1:0]  lane_mask,
    output logic              cnt_illegal
);

    link_st_t st_d, st_q;
    logic     cnt_ok;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = LINK_RST;
        end else if (wr_valid) begin
            if (wr_addr == A_RATE) begin
                st_d.rate = wr_data;
            end else if (wr_addr == A_COUNT) begin
                st_d.cnt     = wr_data[CNT_W-1:0];
                st_d.cnt_set = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINK_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        cnt_ok      = ($countones(st_q.cnt) == 1) && (int'(st_q.cnt) <= LANES);
        cnt_illegal = st_q.cnt_set && !cnt_ok;
        rate_high   = (st_q.rate == RATE_HI_CODE);
        for (int i = 0; i < LANES; i++) begin
            lane_mask[i] = cnt_ok && (i < int'(st_q.cnt));
        end
    end

    // R2: rate select follows the byte written in the previous cycle
    a_r2_rate_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !clear && wr_addr == A_RATE) |=> (rate_high == ($past(wr_data) == RATE_HI_CODE)));

    // R3: mask is always thermometer shaped
    a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_mask & (lane_mask + 1'b1)) == '0));

endmodule

// File: rtl/dpcd_lane_cfg.sv
module dpcd_lane_cfg
    import dpcd_snoop_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LANE_ADDR = A_LANE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] swing_in,
    input  logic [CODE_W-1:0] pre_in,
    output logic [CODE_W-1:0] swing,
    output logic [CODE_W-1:0] pre,
    output logic              illegal
);

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (wr_valid && wr_addr == LANE_ADDR) begin
            st_d.swing = swing_in;
            st_d.pre   = pre_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign swing   = st_q.swing;
    assign pre     = st_q.pre;
    assign illegal = !pair_legal(st_q.swing, st_q.pre);

    // R5: a write to this lane lands in its fields one cycle later
    a_r5_lane_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !clear && wr_addr == LANE_ADDR) |=> (swing == $past(swing_in) && pre == $past(pre_in)));

endmodule

// File: rtl/dpcd_power_ctl.sv
module dpcd_power_ctl
    import dpcd_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        code_in,
    output logic              pwr_down,
    output logic              d3_enter,
    output logic              d3_exit
);

    pwr_st_t   st_d, st_q;
    pwr_code_e code;
    logic      hit;

    always_comb begin
        code       = pwr_code_e'(code_in);
        hit        = wr_valid && (wr_addr == A_POWER);
        st_d       = st_q;
        st_d.enter = 1'b0;
        st_d.leave = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (hit) begin
            unique case (code)
                PWR_DOWN: begin
                    if (!st_q.down) begin
                        st_d.down  = 1'b1;
                        st_d.enter = 1'b1;
                    end
                end
                PWR_NORMAL: begin
                    if (st_q.down) begin
                        st_d.down  = 1'b0;
                        st_d.leave = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwr_down = st_q.down;
    assign d3_enter = st_q.enter;
    assign d3_exit  = st_q.leave;

    // R7: entry pulse only on a real transition into power-down
    a_r7_enter_edge: assert property (@(posedge clk) disable iff (!rst_n)
        d3_enter |-> (pwr_down && !$past(pwr_down)));

    // R7: exit pulse only on a real transition out of power-down
    a_r7_exit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        d3_exit |-> (!pwr_down && $past(pwr_down)));

    // R7: the two pulses never coincide
    a_r7_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(d3_enter && d3_exit));

    // R8: reserved codes leave the power state alone
    a_r8_rsvd_code: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear && (code_in == 2'b00 || code_in == 2'b11)) |=> ($stable(pwr_down) && !d3_enter && !d3_exit));

endmodule

// File: rtl/dpcd_snoop_top.sv
module dpcd_snoop_top
    import dpcd_snoop_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shutdown,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      rate_high,
    output logic [N_LANES-1:0]        lane_en,
    output logic [CODE_W*N_LANES-1:0] swing_lvl,
    output logic [CODE_W*N_LANES-1:0] preemph_lvl,
    output logic                      pwr_down,
    output logic                      d3_enter,
    output logic                      d3_exit,
    output logic                      out_disable
);

    logic [N_LANES-1:0] lane_mask;
    logic [N_LANES-1:0] lane_bad;
    logic               cnt_bad;
    logic               addr_known;

    dpcd_link_cfg #(.LANES(N_LANES)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (shutdown),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rate_high   (rate_high),
        .lane_mask   (lane_mask),
        .cnt_illegal (cnt_bad)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dpcd_lane_cfg #(.LANE_ADDR(A_LANE0 + ADDR_W'(g))) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (shutdown),
            .wr_valid (wr_valid),
            .wr_addr  (wr_addr),
            .swing_in (wr_data[1:0]),
            .pre_in   (wr_data[4:3]),
            .swing    (swing_lvl[CODE_W*g +: CODE_W]),
            .pre      (preemph_lvl[CODE_W*g +: CODE_W]),
            .illegal  (lane_bad[g])
        );
    end

    dpcd_power_ctl u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (shutdown),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .code_in  (wr_data[1:0]),
        .pwr_down (pwr_down),
        .d3_enter (d3_enter),
        .d3_exit  (d3_exit)
    );

    assign out_disable = cnt_bad || (|lane_bad);
    assign lane_en     = out_disable ? '0 : lane_mask;

    assign addr_known = (wr_addr == A_RATE) || (wr_addr == A_COUNT) || (wr_addr == A_POWER) ||
                        ((wr_addr >= A_LANE0) && (wr_addr < A_LANE0 + ADDR_W'(N_LANES)));

    // R4/R6: no lane may run while any entry is illegal
    a_r6_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> (lane_en == '0));

    // R9: unlisted addresses change nothing visible
    a_r9_unlisted: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !addr_known && !shutdown) |=>
        $stable({rate_high, lane_en, swing_lvl, preemph_lvl, pwr_down, out_disable}));

    // R10: after a shutdown cycle everything sits at its defaults
    a_r10_shutdown_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shutdown) |-> (!rate_high && lane_en == '0 && swing_lvl == '0 && preemph_lvl == '0 &&
                             !pwr_down && !d3_enter && !d3_exit && !out_disable));

endmodule

// File: tb/dpcd_snoop_top_tb.sv
`timescale 1ns/1ps
module dpcd_snoop_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        shutdown;
    logic        wr_valid;
    logic [19:0] wr_addr;
    logic [7:0]  wr_data;
    logic        rate_high;
    logic [3:0]  lane_en;
    logic [7:0]  swing_lvl;
    logic [7:0]  preemph_lvl;
    logic        pwr_down;
    logic        d3_enter;
    logic        d3_exit;
    logic        out_disable;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dpcd_snoop_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .shutdown    (shutdown),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rate_high   (rate_high),
        .lane_en     (lane_en),
        .swing_lvl   (swing_lvl),
        .preemph_lvl (preemph_lvl),
        .pwr_down    (pwr_down),
        .d3_enter    (d3_enter),
        .d3_exit     (d3_exit),
        .out_disable (out_disable)
    );

    typedef struct packed {
        logic [19:0] addr;
        logic [7:0]  data;
        logic        rate;
        logic [3:0]  lanes;
        logic        dis;
        logic [7:0]  swing;
        logic [7:0]  pre;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{20'h00100, 8'h0A, 1'b1, 4'b0000, 1'b0, 8'h00, 8'h00},  // R2 high rate
        '{20'h00100, 8'h14, 1'b0, 4'b0000, 1'b0, 8'h00, 8'h00},  // R2 other byte
        '{20'h00100, 8'h0A, 1'b1, 4'b0000, 1'b0, 8'h00, 8'h00},  // R2
        '{20'h00101, 8'h02, 1'b1, 4'b0011, 1'b0, 8'h00, 8'h00},  // R3 two lanes
        '{20'h00101, 8'h84, 1'b1, 4'b1111, 1'b0, 8'h00, 8'h00},  // R3 upper bits ignored
        '{20'h00101, 8'h01, 1'b1, 4'b0001, 1'b0, 8'h00, 8'h00},  // R3 one lane
        '{20'h00101, 8'h03, 1'b1, 4'b0000, 1'b1, 8'h00, 8'h00},  // R4 bad count
        '{20'h00101, 8'h04, 1'b1, 4'b1111, 1'b0, 8'h00, 8'h00},  // R4 recover
        '{20'h00104, 8'h12, 1'b1, 4'b0000, 1'b1, 8'h08, 8'h08},  // R6 lane1 10/10
        '{20'h00105, 8'h09, 1'b1, 4'b0000, 1'b1, 8'h18, 8'h18},  // R5 lane2 legal, still off
        '{20'h00104, 8'h0A, 1'b1, 4'b1111, 1'b0, 8'h18, 8'h14},  // R6 clears
        '{20'h00106, 8'h1B, 1'b1, 4'b0000, 1'b1, 8'hD8, 8'hD4},  // R6 lane3 11/11
        '{20'h00106, 8'h18, 1'b1, 4'b1111, 1'b0, 8'h18, 8'hD4},  // R5 lane3 00/11
        '{20'h00102, 8'hFF, 1'b1, 4'b1111, 1'b0, 8'h18, 8'hD4},  // R9 gap address
        '{20'h00103, 8'h19, 1'b1, 4'b0000, 1'b1, 8'h19, 8'hD7},  // R6 lane0 01/11
        '{20'h00103, 8'h01, 1'b1, 4'b1111, 1'b0, 8'h19, 8'hD4},  // R5 lane0
        '{20'h00101, 8'h00, 1'b1, 4'b0000, 1'b1, 8'h19, 8'hD4},  // R4 zero count
        '{20'h00101, 8'h02, 1'b1, 4'b0011, 1'b0, 8'h19, 8'hD4}   // R11 next-cycle update
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    function automatic logic [63:0] outs();
        return {39'd0, rate_high, lane_en, out_disable, swing_lvl, preemph_lvl, pwr_down, d3_enter, d3_exit};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        shutdown = 1'b0;
        wr_valid = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", outs(), 64'd0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].data);
            check($sformatf("R2/R3/R4/R5/R6/R9 vector %0d", i),
                  {rate_high, lane_en, out_disable, swing_lvl, preemph_lvl},
                  {VEC[i].rate, VEC[i].lanes, VEC[i].dis, VEC[i].swing, VEC[i].pre});
        end

        // R7 power-down entry and one-cycle pulse
        wr(20'h00600, 8'h02);
        check("R7 enter state", {pwr_down, d3_enter, d3_exit}, 3'b110);
        @(negedge clk);
        check("R7 enter pulse width", {pwr_down, d3_enter, d3_exit}, 3'b100);
        // R7 second power-down write gives no extra pulse
        wr(20'h00600, 8'h02);
        check("R7 repeat down", {pwr_down, d3_enter, d3_exit}, 3'b100);
        // R8 reserved codes
        wr(20'h00600, 8'h00);
        check("R8 code 00", {pwr_down, d3_enter, d3_exit}, 3'b100);
        wr(20'h00600, 8'hF3);
        check("R8 code 11", {pwr_down, d3_enter, d3_exit}, 3'b100);
        // R9 power register neighbour ignored
        wr(20'h00601, 8'h01);
        check("R9 near power addr", {pwr_down, d3_enter, d3_exit}, 3'b100);
        // R7 exit
        wr(20'h00600, 8'h01);
        check("R7 exit state", {pwr_down, d3_enter, d3_exit}, 3'b001);
        @(negedge clk);
        check("R7 exit pulse width", {pwr_down, d3_enter, d3_exit}, 3'b000);
        wr(20'h00600, 8'h01);
        check("R7 normal again no pulse", {pwr_down, d3_enter, d3_exit}, 3'b000);
        // R8 reserved code while normal keeps normal mode
        wr(20'h00600, 8'h03);
        check("R8 code 11 in normal", {pwr_down, d3_enter, d3_exit}, 3'b000);

        // R10 shutdown clears and blocks writes
        wr(20'h00600, 8'h02);
        @(negedge clk);
        shutdown = 1'b1;
        @(negedge clk);
        check("R10 shutdown defaults", outs(), 64'd0);
        wr(20'h00100, 8'h0A);
        wr(20'h00101, 8'h04);
        wr(20'h00103, 8'h1B);
        check("R10 writes discarded", outs(), 64'd0);
        shutdown = 1'b0;
        @(negedge clk);
        check("R10 after release", outs(), 64'd0);

        // R11 output appears right after the sampling edge, not before
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = 20'h00101;
        wr_data  = 8'h04;
        @(posedge clk);
        #1;
        check("R11 after edge", {28'd0, lane_en}, 32'h0000000F);
        @(negedge clk);
        wr_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule